// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. Sixteen signals enter it: eight dedicated inputs and eight feedback or pin signals. Each signal is presented to the array in true and in complemented form, which gives thirty-two array lines. Sixty-four product terms each form a wide AND over the lines whose connection cell is closed. The terms are split into eight groups, one per output. In each group, seven terms always feed that output's OR. An eighth term either joins the OR or drives a separate enable output, as a per-output mode bit selects. The output macrocells and pin drivers sit outside this block and consume these sum and enable results.

The connection cells are written one term row at a time through a word-wide configuration port. A bulk erase opens every cell. The port acts only while program-enable is high, and during that time both output buses are forced to zero. An open cell leaves its line out of the AND. A term with no closed cell is therefore true. A term closed onto both polarities of one signal is always false, so it never affects its OR.

Top module: `sop_array_top`

## Requirements
- R1: Array line 2k carries signal k and line 2k+1 carries its complement. Signals 0 to 7 are `dedIn[0..7]` and signals 8 to 15 are `fbIn[0..7]`.
- R2: Term rows are numbered o*8+j. Rows with j from 0 to 6 always feed the OR of output o. Row o*8+7 is the extra term of output o.
- R3: A term is true exactly when every line whose connection bit is 1 is high. A row of all zeros (fully open) is true.
- R4: A term whose row connects both line 2k and line 2k+1 is false for every input value.
- R5: With `xtraMode[o]`=0 the extra term is ORed into `sumOut[o]` and `enOut[o]` is 0. With `xtraMode[o]`=1 the extra term drives `enOut[o]` and is left out of `sumOut[o]`.
- R6: `sumOut` and `enOut` are registered. They reflect the inputs and the connection state one clock after they are applied.
- R7: While `progEn` is high, `cfgWrite` stores `cfgData` into row `cfgAddr` at the clock edge. Bit n of the row is the connection to line n, and 1 means closed.
- R8: While `progEn` is high, `cfgErase` opens every connection cell at the clock edge.
- R9: When an erase and a write fall on the same edge, the addressed row takes `cfgData` and every other row is opened.
- R10: While `progEn` is low, `cfgWrite` and `cfgErase` leave the connection state unchanged.
- R11: One clock after `progEn` is seen high, `sumOut` and `enOut` are all zero.
- R12: Synchronous reset `rst` opens all cells and clears both output buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| progEn | input | 1 | Program enable; gates the configuration port and holds the outputs at zero |
| cfgWrite | input | 1 | Write the row at `cfgAddr` |
| cfgErase | input | 1 | Bulk erase: open all cells |
| cfgAddr | input | 6 | Term row index |
| cfgData | input | 32 | Row connection bits, one per array line |
| dedIn | input | 8 | Dedicated input signals |
| fbIn | input | 8 | Feedback / pin input signals |
| xtraMode | input | 8 | Per-output routing of the extra term (1 = enable) |
| sumOut | output | 8 | Registered sum-of-products results |
| enOut | output | 8 | Registered enable terms |

## Verification
The bulk erase and a row write can land on the same clock edge. The bench provokes this after it has preloaded a row that is not addressed. It then reads the outcome through the enable outputs, which shows that the written row survives and the preloaded row was opened. The second collision is the mode bit changing on the same edge as the inputs. A behavioural model evaluates every term row by row, and its result is compared with the outputs on every clock.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Strobes from the configuration control to the connection store.
  typedef struct packed {
    logic wrStb;
    logic eraseStb;
  } cfgStrobes_t;

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
  import sop_pkg::*;
(
  input  logic        progEn,
  input  logic        cfgWrite,
  input  logic        cfgErase,
  output cfgStrobes_t stb,
  output logic        holdOut
);

  always_comb begin
    stb.wrStb    = progEn & cfgWrite;
    stb.eraseStb = progEn & cfgErase;
    holdOut      = progEn;
  end

endmodule

// File: rtl/sop_conn_store.sv
module sop_conn_store
  import sop_pkg::*;
#(
  parameter int TERMS  = 64,
  parameter int LINES  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cfgStrobes_t            stb,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [LINES-1:0]       cfgData,
  output logic [TERMS*LINES-1:0] connFlat
);

  for (genvar r = 0; r < TERMS; r++) begin : gRow
    logic [LINES-1:0] rowBits;
    logic             hit;
    assign hit = stb.wrStb && (cfgAddr == ADDR_W'(r));
    always_ff @(posedge clk) begin
      if (rst)               rowBits <= '0;
      else if (hit)          rowBits <= cfgData;
      else if (stb.eraseStb) rowBits <= '0;
    end
    assign connFlat[r*LINES +: LINES] = rowBits;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    stb.wrStb |=> connFlat[$past(cfgAddr)*LINES +: LINES] == $past(cfgData)); // R7

  AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (rst)
    (stb.eraseStb && !stb.wrStb) |=> (connFlat == '0)); // R8

  AST_ERASE_WRITE_MIX: assert property (@(posedge clk) disable iff (rst)
    (stb.eraseStb && stb.wrStb) |=> ($countones(connFlat) == $countones($past(cfgData)))); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!stb.wrStb && !stb.eraseStb) |=> $stable(connFlat)); // R10

endmodule

// File: rtl/sop_eval.sv
module sop_eval #(
  parameter int NUM_DED       = 8,
  parameter int NUM_FB        = 8,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 7,
  localparam int SIGS  = NUM_DED + NUM_FB,
  localparam int LINES = 2 * SIGS,
  localparam int GROUP = TERMS_PER_OUT + 1,
  localparam int TERMS = NUM_OUT * GROUP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   holdOut,
  input  logic [NUM_DED-1:0]     dedIn,
  input  logic [NUM_FB-1:0]      fbIn,
  input  logic [NUM_OUT-1:0]     xtraMode,
  input  logic [TERMS*LINES-1:0] connFlat,
  output logic [NUM_OUT-1:0]     sumOut,
  output logic [NUM_OUT-1:0]     enOut
);

  logic [SIGS-1:0]    sigs;
  logic [LINES-1:0]   lines;
  logic [TERMS-1:0]   termVal;
  logic [NUM_OUT-1:0] sumNext;
  logic [NUM_OUT-1:0] enNext;

  assign sigs = {fbIn, dedIn};

  for (genvar k = 0; k < SIGS; k++) begin : gLine
    assign lines[2*k]   = sigs[k];
    assign lines[2*k+1] = ~sigs[k];
  end

  // An open cell (0) forces its line to 1 inside the AND.
  for (genvar t = 0; t < TERMS; t++) begin : gTerm
    assign termVal[t] = &(lines | ~connFlat[t*LINES +: LINES]);
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    logic orPart;
    logic xtra;
    assign orPart     = |termVal[o*GROUP +: TERMS_PER_OUT];
    assign xtra       = termVal[o*GROUP + TERMS_PER_OUT];
    assign sumNext[o] = orPart | (xtra & ~xtraMode[o]);
    assign enNext[o]  = xtra & xtraMode[o];
  end

  always_ff @(posedge clk) begin
    if (rst || holdOut) begin
      sumOut <= '0;
      enOut  <= '0;
    end else begin
      sumOut <= sumNext;
      enOut  <= enNext;
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    holdOut |=> (sumOut == '0 && enOut == '0)); // R11

  AST_EN_ONLY_MODE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((enOut & ~$past(xtraMode)) == '0)); // R5

  AST_OPEN_TRUE: assert property (@(posedge clk) disable iff (rst)
    (connFlat == '0 && !holdOut) |=> (sumOut == '1 && enOut == $past(xtraMode))); // R3

endmodule

// File: rtl/sop_array_top.sv
module sop_array_top
  import sop_pkg::*;
#(
  parameter int NUM_DED       = 8,
  parameter int NUM_FB        = 8,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 7,
  localparam int LINES  = 2 * (NUM_DED + NUM_FB),
  localparam int TERMS  = NUM_OUT * (TERMS_PER_OUT + 1),
  localparam int ADDR_W = $clog2(TERMS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progEn,
  input  logic               cfgWrite,
  input  logic               cfgErase,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [LINES-1:0]   cfgData,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_FB-1:0]  fbIn,
  input  logic [NUM_OUT-1:0] xtraMode,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_OUT-1:0] enOut
);

  cfgStrobes_t            stb;
  logic                   holdOut;
  logic [TERMS*LINES-1:0] connFlat;

  sop_cfg_ctrl ctrl_i (
    .progEn   (progEn),
    .cfgWrite (cfgWrite),
    .cfgErase (cfgErase),
    .stb      (stb),
    .holdOut  (holdOut)
  );

  sop_conn_store #(
    .TERMS  (TERMS),
    .LINES  (LINES),
    .ADDR_W (ADDR_W)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .connFlat (connFlat)
  );

  sop_eval #(
    .NUM_DED       (NUM_DED),
    .NUM_FB        (NUM_FB),
    .NUM_OUT       (NUM_OUT),
    .TERMS_PER_OUT (TERMS_PER_OUT)
  ) eval_i (
    .clk      (clk),
    .rst      (rst),
    .holdOut  (holdOut),
    .dedIn    (dedIn),
    .fbIn     (fbIn),
    .xtraMode (xtraMode),
    .connFlat (connFlat),
    .sumOut   (sumOut),
    .enOut    (enOut)
  );

endmodule

// File: tb/sop_array_top_tb.sv
`timescale 1ns/1ps
module sop_array_top_tb_top;

  localparam int NT = 64;
  localparam int NO = 8;
  localparam int WATCHDOG_NS = 150000 * 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progEn = 1'b0, cfgWrite = 1'b0, cfgErase = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [7:0]  dedIn = '0, fbIn = '0, xtraMode = '0;
  logic [7:0]  sumOut, enOut;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curReq  = "R12";

  always #10 clk = ~clk;

  sop_array_top dut_i (
    .clk(clk), .rst(rst), .progEn(progEn), .cfgWrite(cfgWrite),
    .cfgErase(cfgErase), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .dedIn(dedIn), .fbIn(fbIn), .xtraMode(xtraMode),
    .sumOut(sumOut), .enOut(enOut)
  );

  // Behavioural reference model
  logic [31:0] mConn [NT];
  logic [7:0]  expSum, expEn;

  function automatic bit termTrue(logic [31:0] c, logic [7:0] d, logic [7:0] f);
    for (int l = 0; l < 32; l++) begin
      if (c[l]) begin
        bit s;
        s = (l / 2 < 8) ? d[l/2] : f[l/2 - 8];
        if ((l % 2) == 1) s = !s;
        if (!s) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NT; t++) mConn[t] = '0;
      expSum = '0;
      expEn  = '0;
    end else begin
      if (progEn) begin
        expSum = '0;
        expEn  = '0;
      end else begin
        for (int o = 0; o < NO; o++) begin
          bit acc;
          bit x;
          acc = 1'b0;
          for (int j = 0; j < 7; j++) acc = acc | termTrue(mConn[o*8+j], dedIn, fbIn);
          x = termTrue(mConn[o*8+7], dedIn, fbIn);
          if (xtraMode[o]) begin
            expSum[o] = acc;
            expEn[o]  = x;
          end else begin
            expSum[o] = acc | x;
            expEn[o]  = 1'b0;
          end
        end
      end
      if (progEn) begin
        if (cfgErase) for (int t = 0; t < NT; t++) mConn[t] = '0;
        if (cfgWrite) mConn[cfgAddr] = cfgData;
      end
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Advance to the next falling edge and compare against the model.
  task automatic cycle();
    @(negedge clk);
    chk(curReq, "sumOut", sumOut, expSum);
    chk(curReq, "enOut", enOut, expEn);
  endtask

  task automatic wrRow(logic [5:0] a, logic [31:0] d);
    progEn = 1'b1; cfgWrite = 1'b1; cfgAddr = a; cfgData = d;
    cycle();
    cfgWrite = 1'b0; progEn = 1'b0;
  endtask

  task automatic eraseAll();
    progEn = 1'b1; cfgErase = 1'b1;
    cycle();
    cfgErase = 1'b0; progEn = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    // R12: reset clears outputs and opens every cell
    repeat (3) @(negedge clk);
    chk("R12", "sumOut in reset", sumOut, 8'h00);
    chk("R12", "enOut in reset", enOut, 8'h00);
    rst = 1'b0;
    cycle();
    chk("R12", "open array after reset", sumOut, 8'hFF);

    // R3 and R8: an open array gives true terms in both modes
    curReq = "R3";
    xtraMode = 8'hFF;
    cycle();
    chk("R3", "open terms to enable", enOut, 8'hFF);
    xtraMode = 8'h00;

    // R1, R2, R4: program group 0 by hand
    curReq = "R7";
    eraseAll();
    wrRow(6'd0, 32'h0000_0001);                          // dedIn[0] true
    for (int j = 1; j < 7; j++) wrRow(6'(j), 32'h0000_0003); // both polarities of signal 0
    wrRow(6'd7, 32'h0080_0000);                          // line 23: complement of fbIn[3]
    curReq = "R1";
    dedIn = 8'h00; fbIn = 8'h08;
    cycle();
    chk("R4", "contradictory terms stay false", sumOut[0] ? 8'h1 : 8'h0, 8'h0);
    // R6: a new input does not show before the next edge
    dedIn = 8'h01;
    #2;
    chk("R6", "no change before edge", sumOut[0] ? 8'h1 : 8'h0, 8'h0);
    cycle();
    chk("R1", "dedIn[0] true line", sumOut[0] ? 8'h1 : 8'h0, 8'h1);
    dedIn = 8'h00; fbIn = 8'h00;
    cycle();
    chk("R2", "extra term of output 0 in sum", sumOut[0] ? 8'h1 : 8'h0, 8'h1);
    curReq = "R5";
    xtraMode = 8'h01;
    cycle();
    chk("R5", "extra term moved to enable", {6'd0, enOut[0], sumOut[0]}, 8'h2);
    xtraMode = 8'h00;

    // R10: writes and erase ignored while programming is off
    curReq = "R10";
    dedIn = 8'h00; fbIn = 8'h08;
    cfgWrite = 1'b1; cfgAddr = 6'd1; cfgData = 32'h0;
    cycle();
    cfgWrite = 1'b0; cfgErase = 1'b1;
    cycle();
    cfgErase = 1'b0;
    cycle();
    chk("R10", "output 0 keeps its pattern", sumOut[0] ? 8'h1 : 8'h0, 8'h0);

    // R11: outputs forced to zero while programming
    curReq = "R11";
    dedIn = 8'h01;
    progEn = 1'b1;
    cycle();
    chk("R11", "sum held low", sumOut, 8'h00);
    progEn = 1'b0;
    cycle();

    // R9: erase and write on the same edge
    curReq = "R9";
    wrRow(6'd15, 32'h0000_0003);
    progEn = 1'b1; cfgErase = 1'b1; cfgWrite = 1'b1; cfgAddr = 6'd7; cfgData = 32'h0000_0003;
    cycle();
    progEn = 1'b0; cfgErase = 1'b0; cfgWrite = 1'b0;
    xtraMode = 8'hFF;
    cycle();
    chk("R9", "written row kept, others opened", enOut, 8'hFE);
    chk("R9", "sums after mixed erase", sumOut, 8'hFF);

    // R5, R6: random patterns and inputs against the model
    for (int p = 0; p < 4; p++) begin
      curReq = "R7";
      eraseAll();
      for (int t = 0; t < NT; t++)
        wrRow(6'(t), $urandom & $urandom & $urandom & $urandom);
      curReq = (p % 2 == 0) ? "R5" : "R6";
      for (int n = 0; n < 300; n++) begin
        dedIn = 8'($urandom); fbIn = 8'($urandom); xtraMode = 8'($urandom);
        cycle();
      end
    end

    done = 1'b1;
    report();
  end

endmodule